// File: doc/BRIEF.md
# Radix-4 Carry-Save Montgomery Multiplier

This block multiplies two operands modulo an odd modulus using the Montgomery method with radix-4 digits. It returns A·B·4^(−n) mod M, where n is the operand length in radix-4 digits chosen per run. Internally the multiplicand is scaled by 16 before the loop, and the loop runs n+2 times. Each pass draws one signed multiplier digit from A and one signed quotient digit, adds the two partial products into a carry-save accumulator through two 3:2 compressor stages, and divides by four. The quotient digit therefore depends only on the two low bits of the accumulator and on whether M is 1 or 3 modulo 4. After the loop the redundant accumulator is collapsed to binary in one cycle. One further cycle adds or subtracts M once to bring the value into [0, M).

Operands enter through a valid/ready handshake. A transfer occurs on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is high only while the block is idle with no result waiting. The result leaves through a second valid/ready pair. While `out_ready` is low the block holds `out_valid` and `res_out` and accepts nothing new, so back-pressure on the output stalls the input side. The caller must supply A < 4^n, B < M, M odd with M < 4^n, and 1 ≤ n ≤ W/2.

Top module: `mont_r4_mul`

## Requirements
- R1: `in_ready` is high only when no run is in progress and no result is waiting. Operands are taken on a rising edge with `in_valid` and `in_ready` both high, and `in_ready` stays low from the next cycle until the result has been handed over.
- R2: For odd M, A < 4^n, B < M, M < 4^n and 1 ≤ n ≤ W/2, `res_out` equals A·B·4^(−n) mod M.
- R3: Every presented result lies in [0, M), even when the accumulator ends below zero or at or above M before the final correction.
- R4: The result is correct both for M ≡ 3 (mod 4), where the quotient digit equals the accumulator's low radix-4 digit, and for M ≡ 1 (mod 4), where it equals the negation of that digit modulo 4. Quotient digit codes 0, 1, 2 and 3 stand for the values 0, +1, +2 and −1.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `res_out` does not change. After the edge that takes the result, `out_valid` is low and `in_ready` is high.
- R6: `out_valid` first goes high after exactly n+4 rising edges following the accepting edge: n+2 iterations, one conversion cycle and one correction cycle.
- R7: Values on `a_in`, `b_in`, `m_in`, `len_in` and `in_valid` while a run is in progress do not alter that run's result.
- R8: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle and able to take operands |
| a_in | input | W | Multiplier A, unsigned |
| b_in | input | W | Multiplicand B, unsigned, below M |
| m_in | input | W | Odd modulus M |
| len_in | input | $clog2(W/2+2) | Operand length n in radix-4 digits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res_out | output | W | A·B·4^(−n) mod M |

## Verification
The bench targets the smallest length (n = 1, M = 3) and the full width with the modulus at 2^W−1 and at 2^W−3, so that both quotient rules run with operands at their limits. A wrong quotient rule for one residue class leaves low accumulator bits that the shift discards, and the result is then off by a multiple of a power of four. A sign error on a digit of −1, or a lost carry from the 16× pre-scale, gives values far from the reference. A one-sided final correction shows up as results at or above M, or as wrapped negative values, on random moduli whose quotient sums end the loop below zero. Holding `out_ready` low for several cycles and changing the inputs during a run exposes designs that re-sample operands or let the result change while it is held.

// File: rtl/mont_r4_pkg.sv
package mont_r4_pkg;

  // Signed radix-4 digit; the code equals the digit value modulo 4.
  typedef enum logic [1:0] {
    DIG_ZERO = 2'd0,
    DIG_ONE  = 2'd1,
    DIG_TWO  = 2'd2,
    DIG_NEG  = 2'd3
  } sdig_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SUM,
    ST_FIX,
    ST_OUT
  } mstate_t;

endpackage

// File: rtl/mont_a_recode.sv
// Turns one unsigned radix-4 digit of A plus an incoming carry into a
// digit in {-1, 0, 1, 2} and an outgoing carry.
module mont_a_recode
  import mont_r4_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       cin,
  output sdig_t      dig,
  output logic       cout
);

  logic [2:0] raw;

  always_comb begin
    raw  = {1'b0, pair} + {2'b00, cin};
    dig  = DIG_ZERO;
    cout = 1'b0;
    case (raw)
      3'd0: begin dig = DIG_ZERO; cout = 1'b0; end
      3'd1: begin dig = DIG_ONE;  cout = 1'b0; end
      3'd2: begin dig = DIG_TWO;  cout = 1'b0; end
      3'd3: begin dig = DIG_NEG;  cout = 1'b1; end
      default: begin dig = DIG_ZERO; cout = 1'b1; end
    endcase
  end

endmodule

// File: rtl/mont_q_select.sv
// Quotient digit from the low radix-4 digit of the carry-save accumulator.
// The multiplicand is pre-scaled by 16, so no term of B is involved.
module mont_q_select
  import mont_r4_pkg::*;
(
  input  logic [1:0] s_lo,
  input  logic [1:0] c_lo,
  input  logic       k_in,
  input  logic       m_is3,
  output sdig_t      q
);

  logic [1:0] r0;
  logic [1:0] t;

  always_comb begin
    r0 = s_lo + c_lo + {1'b0, k_in};
    t  = m_is3 ? r0 : (2'd0 - r0);
    q  = sdig_t'(t);
  end

endmodule

// File: rtl/mont_csa_iter.sv
// One radix-4 iteration: select both partial products, compress them with
// the accumulator in two 3:2 stages, then divide the redundant sum by four.
// The sum and carry vectors are exact signed integers; the carry bit that
// the shift would lose is handed back as k_out.
module mont_csa_iter
  import mont_r4_pkg::*;
#(
  parameter int IW = 70
) (
  input  logic [IW-1:0] s_in,
  input  logic [IW-1:0] c_in,
  input  logic          k_in,
  input  sdig_t         da,
  input  sdig_t         dq,
  input  logic [IW-1:0] b_pos,
  input  logic [IW-1:0] b_neg,
  input  logic [IW-1:0] m_pos,
  input  logic [IW-1:0] m_neg,
  output logic [IW-1:0] s_out,
  output logic [IW-1:0] c_out,
  output logic          k_out,
  output logic [1:0]    lsb_sum,
  output logic          lsb_carry
);

  function automatic logic [IW-1:0] pick(input sdig_t d,
                                         input logic [IW-1:0] pos,
                                         input logic [IW-1:0] neg);
    case (d)
      DIG_ZERO: pick = '0;
      DIG_ONE:  pick = pos;
      DIG_TWO:  pick = pos << 1;
      default:  pick = neg;
    endcase
  endfunction

  logic [IW-1:0] pa, pq;
  logic [IW-1:0] sum1, maj1;
  logic [IW:0]   car1, x2, z2, sum2, maj2;

  always_comb begin
    pa   = pick(da, b_pos, b_neg);
    pq   = pick(dq, m_pos, m_neg);
    // stage 1: accumulator plus A-digit term; pending carry fills the free LSB
    sum1 = s_in ^ c_in ^ pa;
    maj1 = (s_in & c_in) | (s_in & pa) | (c_in & pa);
    car1 = {maj1, k_in};
    // stage 2: add the quotient term, one bit wider
    x2   = {sum1[IW-1], sum1};
    z2   = {pq[IW-1], pq};
    sum2 = x2 ^ car1 ^ z2;
    maj2 = (x2 & car1) | (x2 & z2) | (car1 & z2);
    // divide by four: sum2 + 2*maj2 is a multiple of four
    s_out     = {sum2[IW], sum2[IW:2]};
    c_out     = maj2[IW:1];
    k_out     = maj2[0];
    lsb_sum   = sum2[1:0];
    lsb_carry = maj2[0];
  end

endmodule

// File: rtl/mont_final_fix.sv
// One-step correction of the binary accumulator into [0, M).
module mont_final_fix #(
  parameter int IW = 70
) (
  input  logic [IW:0]   rb,
  input  logic [IW-1:0] m,
  output logic [IW:0]   r
);

  logic [IW:0] mx;

  always_comb begin
    mx = {1'b0, m};
    if (rb[IW])        r = rb + mx;
    else if (rb >= mx) r = rb - mx;
    else               r = rb;
  end

endmodule

// File: rtl/mont_r4_mul.sv
module mont_r4_mul
  import mont_r4_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [W-1:0]                a_in,
  input  logic [W-1:0]                b_in,
  input  logic [W-1:0]                m_in,
  input  logic [$clog2(W/2+2)-1:0]    len_in,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [W-1:0]                res_out
);

  localparam int ND = W / 2;
  localparam int LW = $clog2(ND + 2);
  localparam int IW = W + 6;

  mstate_t       state;
  logic [IW-1:0] s_r, c_r;
  logic          k_r;
  logic [W-1:0]  a_r;
  logic          acar_r;
  logic [IW-1:0] bp_r, bn_r, mp_r, mn_r;
  logic          m3_r;
  logic [LW-1:0] n_r, it_r;
  logic [IW:0]   rb_r, res_r;

  sdig_t         a_dig, q_dig;
  logic          a_cout;
  logic [IW-1:0] s_nx, c_nx;
  logic          k_nx;
  logic [1:0]    lsb_sum;
  logic          lsb_carry;
  logic [IW:0]   fixed;
  logic [IW-1:0] b_scaled, m_ext;

  assign b_scaled = {{(IW-W-4){1'b0}}, b_in, 4'b0000};
  assign m_ext    = {{(IW-W){1'b0}}, m_in};

  mont_a_recode u_rec (
    .pair (a_r[1:0]),
    .cin  (acar_r),
    .dig  (a_dig),
    .cout (a_cout)
  );

  mont_q_select u_qsel (
    .s_lo  (s_r[1:0]),
    .c_lo  (c_r[1:0]),
    .k_in  (k_r),
    .m_is3 (m3_r),
    .q     (q_dig)
  );

  mont_csa_iter #(.IW(IW)) u_iter (
    .s_in      (s_r),
    .c_in      (c_r),
    .k_in      (k_r),
    .da        (a_dig),
    .dq        (q_dig),
    .b_pos     (bp_r),
    .b_neg     (bn_r),
    .m_pos     (mp_r),
    .m_neg     (mn_r),
    .s_out     (s_nx),
    .c_out     (c_nx),
    .k_out     (k_nx),
    .lsb_sum   (lsb_sum),
    .lsb_carry (lsb_carry)
  );

  mont_final_fix #(.IW(IW)) u_fix (
    .rb (rb_r),
    .m  (mp_r),
    .r  (fixed)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign res_out   = res_r[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      s_r    <= '0;
      c_r    <= '0;
      k_r    <= 1'b0;
      a_r    <= '0;
      acar_r <= 1'b0;
      bp_r   <= '0;
      bn_r   <= '0;
      mp_r   <= '0;
      mn_r   <= '0;
      m3_r   <= 1'b0;
      n_r    <= '0;
      it_r   <= '0;
      rb_r   <= '0;
      res_r  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            s_r    <= '0;
            c_r    <= '0;
            k_r    <= 1'b0;
            a_r    <= a_in;
            acar_r <= 1'b0;
            bp_r   <= b_scaled;
            bn_r   <= '0 - b_scaled;
            mp_r   <= m_ext;
            mn_r   <= '0 - m_ext;
            m3_r   <= m_in[1];
            n_r    <= len_in;
            it_r   <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          s_r    <= s_nx;
          c_r    <= c_nx;
          k_r    <= k_nx;
          a_r    <= a_r >> 2;
          acar_r <= a_cout;
          it_r   <= it_r + 1'b1;
          if (it_r == n_r + 1'b1) state <= ST_SUM;
        end
        ST_SUM: begin
          rb_r  <= {s_r[IW-1], s_r} + {c_r[IW-1], c_r} + {{IW{1'b0}}, k_r};
          state <= ST_FIX;
        end
        ST_FIX: begin
          res_r <= fixed;
          state <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: every iteration's redundant sum is an exact multiple of four
  p_exact_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (lsb_sum[0] == 1'b0 && lsb_sum[1] == lsb_carry));

  // R4: the first quotient digit of a run is zero
  p_q0_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && it_r == '0) |-> (q_dig == DIG_ZERO));

  // R3: a presented result is below the modulus
  p_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_r < {1'b0, mp_r}));

  // R5: a held result does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_out)));

  // R1: after a transfer the input side closes
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6: the iteration counter never passes the last iteration
  p_iter_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (it_r <= n_r + 1'b1));

endmodule

// File: tb/mont_r4_mul_tb.sv
module mont_r4_mul_tb;

  localparam int W  = 64;
  localparam int LW = $clog2(W/2 + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  a_in = '0, b_in = '0, m_in = '0;
  logic [LW-1:0] len_in = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  res_out;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  mont_r4_mul #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a_in      (a_in),
    .b_in      (b_in),
    .m_in      (m_in),
    .len_in    (len_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_out   (res_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mont(input logic [63:0] a,
                                           input logic [63:0] b,
                                           input logic [63:0] m,
                                           input int n);
    logic [127:0] x;
    logic [127:0] mm;
    mm = {64'd0, m};
    x  = ({64'd0, a} * {64'd0, b}) % mm;
    for (int i = 0; i < 2 * n; i++) begin
      if (x[0]) x = (x + mm) >> 1;
      else      x = x >> 1;
    end
    return x[63:0];
  endfunction

  task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] m, input int n, input int hold);
    logic [63:0] exp, held;
    int lat;
    exp = ref_mont(a, b, m, n);
    @(negedge clk);
    in_valid = 1'b1;
    a_in = a; b_in = b; m_in = m; len_in = LW'(n);
    @(posedge clk);
    @(negedge clk);
    // R7: garbage offered while busy
    a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom};
    m_in = {$urandom, $urandom}; len_in = LW'($urandom);
    lat = 0;
    while (!out_valid && lat < 200) begin
      chk(!in_ready, "R1 in_ready low while busy", 64'(in_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(lat == n + 4, "R6 latency", 64'(lat), 64'(n + 4));
    held = res_out;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid && res_out == held, "R5 result held under back-pressure",
          res_out, held);
    end
    chk(res_out == exp, m[1] ? "R2 R4 R7 result, M mod 4 = 3"
                             : "R2 R4 R7 result, M mod 4 = 1", res_out, exp);
    chk(res_out < m, "R3 result below M", res_out, m);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R5 handed over, idle again",
        {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, m, mask;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(in_ready && !out_valid, "R8 reset state",
        {62'd0, in_ready, out_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R8 state after reset release",
        {62'd0, in_ready, out_valid}, 64'd2);

    // directed corners
    run_one(64'd3, 64'd2, 64'd3, 1, 0);
    run_one(64'd0, 64'd2, 64'd3, 1, 2);
    run_one('1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 32, 3);
    run_one('1, 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFD, 32, 1);
    run_one(64'd0, 64'h1234_5678, 64'hFFFF_FFFF_FFFF_FFFD, 32, 0);
    run_one(64'd1023, 64'd4, 64'd5, 5, 0);
    run_one(64'd1, 64'd1, 64'h8000_0000_0000_0001, 32, 0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      n = 1 + ($urandom % 32);
      mask = (n == 32) ? '1 : ((64'd1 << (2 * n)) - 64'd1);
      m = ({$urandom, $urandom} & mask) | 64'd1;
      if (i % 2 == 0) m[1] = 1'b1;
      else if (n > 1) m[1] = 1'b0;
      if (m < 64'd3) m = 64'd3;
      b = {$urandom, $urandom} % m;
      a = {$urandom, $urandom} & mask;
      run_one(a, b, m, n, int'($urandom % 4));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule